// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day as a seconds count and a sub-second count. A fixed reference clock drives it. On every reference clock the sub-second count grows by a programmable step. When it reaches its rollover value it wraps, and the seconds count goes up by one in the same clock. The rollover value is either one billion, so the field counts nanoseconds, or a power of two, so the field is a binary fraction of a second.

Two counting modes are available. In coarse mode the step is added on every clock. In fine mode a wide phase accumulator adds a programmable addend on every clock, and the step is taken only on a clock where the accumulator carries out. Software trims the frequency by changing the addend.

Software drives the block through a simple write port. Five register addresses hold the mode bits, the step value, the staged seconds and sub-second operands, and the staged addend. Three command bits start the operations: load the time, step the time by an offset, and take the staged addend. A command bit stays set until its operation is done, then clears itself. A small command state machine has four states: `IDLE`, `LOAD_TIME`, `STEP_TIME` and `LOAD_ADDEND`. From `IDLE` it moves to `LOAD_TIME` if a load is pending. Otherwise it moves to `STEP_TIME` if a step is pending, and otherwise to `LOAD_ADDEND` if an addend load is pending. Each command state applies its operation and clears its bit, then returns to `IDLE` on the next clock.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, the seconds, sub-second, active addend and pending-command outputs are all zero, and the step value is zero.
- R2: In coarse mode (control bit 0 = 0), the sub-second count grows by the step value on every clock. The step value is taken from bits 23:16 of a write to address 1. The active addend has no effect in this mode.
- R3: In fine mode (control bit 0 = 1), the addend is added into a 32-bit accumulator on every clock. The step is taken only on a clock where the accumulator carries out. An addend of 2^31 gives exactly one step per two clocks, and an addend of 0 gives no steps.
- R4: In decimal mode (control bit 1 = 1), the sub-second count wraps at 10^9 and seconds goes up by one. This also holds when a single step crosses the wrap point.
- R5: In binary mode (control bit 1 = 0), the sub-second count wraps at 2^31 and seconds goes up by one.
- R6: Writing 1 to control bit 2 sets the pending-init output bit 0. The block then loads the staged seconds (address 2) and the staged sub-second value (address 3, bits 30:0) into the time. The pending bit clears, and the new time is visible, two clocks after the bit was set.
- R7: Writing 1 to control bit 3, with address 3 bit 31 clear, adds the staged seconds and sub-second values to the time. A carry from the sub-second field goes into seconds, and seconds wrap modulo 2^32.
- R8: When address 3 bit 31 is set, the step command subtracts (y, x) from the time. Seconds are supplied as 2^32−y and the sub-second value as rollover−x, with x between 1 and rollover−1. A borrow takes one from seconds.
- R9: Writing 1 to control bit 4 copies the staged addend (address 4) to the active-addend output, and pending bit 2 clears two clocks later. Writing address 4 without this command leaves the active addend unchanged.
- R10: Only one command is applied per clock, and the load command has priority. If load and step are set in the same write, the load is applied first while the step stays pending (pending bit 1). The step is applied two clocks after that.
- R11: The seconds and sub-second outputs come from registers that update on the same clock edge. On a plain counting clock, seconds changes exactly when the sub-second count wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 step, 2 seconds operand, 3 sub-second operand, 4 addend) |
| wr_data | input | 32 | Register write data |
| time_sec | output | 32 | Current seconds |
| time_sub | output | 31 | Current sub-second count |
| cmd_pending | output | 3 | Pending commands {addend, step, load} |
| addend_active | output | 32 | Addend in use by the accumulator |

## Verification
The bench builds the block with its default parameters: a 32-bit seconds field, a 31-bit sub-second field, a 32-bit accumulator, an 8-bit step at bit 16, and a decimal rollover of 10^9. These are the real field widths, so both wrap points can be reached by loading a time a few steps below them. With the step held at zero, the clock stands still. That lets the bench compare each load and each add or subtract result exactly against its own time arithmetic, in both rollover modes. With a nonzero step, the counting, the wraps and the accumulator rates are checked over fixed clock windows.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD_TIME,
        ST_STEP_TIME,
        ST_LOAD_ADDEND
    } cmd_state_t;

    // register addresses
    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STEP   = 3'd1;
    localparam logic [2:0] A_SEC    = 3'd2;
    localparam logic [2:0] A_SUB    = 3'd3;
    localparam logic [2:0] A_ADDEND = 3'd4;

    // control bit positions
    localparam int C_FINE   = 0;
    localparam int C_DEC    = 1;
    localparam int C_INIT   = 2;
    localparam int C_UPD    = 3;
    localparam int C_ADDEND = 4;

    // pending vector positions
    localparam int P_INIT   = 0;
    localparam int P_UPD    = 1;
    localparam int P_ADDEND = 2;
    localparam int N_CMD    = 3;

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int SEC_W   = 32,
    parameter int SUB_W   = 31,
    parameter int ACC_W   = 32,
    parameter int INC_W   = 8,
    parameter int INC_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N_CMD-1:0]  clr,
    output logic              fine_mode,
    output logic              dec_mode,
    output logic [N_CMD-1:0]  pend,
    output logic [INC_W-1:0]  inc,
    output logic [SEC_W-1:0]  upd_sec,
    output logic [SUB_W-1:0]  upd_sub,
    output logic              upd_neg,
    output logic [ACC_W-1:0]  addend_stage
);

    logic              wr_ctrl;
    logic [N_CMD-1:0]  set_cmd;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign set_cmd = wr_ctrl ? wr_data[C_ADDEND:C_INIT] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_mode    <= 1'b0;
            dec_mode     <= 1'b0;
            pend         <= '0;
            inc          <= '0;
            upd_sec      <= '0;
            upd_sub      <= '0;
            upd_neg      <= 1'b0;
            addend_stage <= '0;
        end else begin
            pend <= (pend & ~clr) | set_cmd;
            if (wr_ctrl) begin
                fine_mode <= wr_data[C_FINE];
                dec_mode  <= wr_data[C_DEC];
            end
            if (wr_en && wr_addr == A_STEP)
                inc <= wr_data[INC_LSB +: INC_W];
            if (wr_en && wr_addr == A_SEC)
                upd_sec <= wr_data[SEC_W-1:0];
            if (wr_en && wr_addr == A_SUB) begin
                upd_sub <= wr_data[SUB_W-1:0];
                upd_neg <= wr_data[DATA_W-1];
            end
            if (wr_en && wr_addr == A_ADDEND)
                addend_stage <= wr_data[ACC_W-1:0];
        end
    end

    // a pending bit only drops when the command engine retires it
    for (genvar g = 0; g < N_CMD; g++) begin : g_pend_chk
        assert_pend_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[g]) |-> $past(clr[g]));
    end

endmodule

// File: rtl/ptp_tc_ctrl.sv
module ptp_tc_ctrl
    import ptp_tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CMD-1:0] pend,
    output logic             do_load,
    output logic             do_step,
    output logic             do_addend,
    output logic [N_CMD-1:0] clr
);

    cmd_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (pend[P_INIT])        state_nx = ST_LOAD_TIME;
                else if (pend[P_UPD])    state_nx = ST_STEP_TIME;
                else if (pend[P_ADDEND]) state_nx = ST_LOAD_ADDEND;
                else                     state_nx = ST_IDLE;
            end
            ST_LOAD_TIME:   state_nx = ST_IDLE;
            ST_STEP_TIME:   state_nx = ST_IDLE;
            ST_LOAD_ADDEND: state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        do_load   = 1'b0;
        do_step   = 1'b0;
        do_addend = 1'b0;
        unique case (state)
            ST_IDLE:        ;
            ST_LOAD_TIME:   do_load   = 1'b1;
            ST_STEP_TIME:   do_step   = 1'b1;
            ST_LOAD_ADDEND: do_addend = 1'b1;
            default:        ;
        endcase
        clr = '0;
        clr[P_INIT]   = do_load;
        clr[P_UPD]    = do_step;
        clr[P_ADDEND] = do_addend;
    end

    assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_load, do_step, do_addend}));

    assert_cmd_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE));

    assert_init_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pend[P_INIT]) |=> do_load);

endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine_mode,
    input  logic             take_addend,
    input  logic [ACC_W-1:0] addend_stage,
    output logic [ACC_W-1:0] addend_active,
    output logic             tick
);

    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   acc_sum;
    logic             carry;

    assign acc_sum = {1'b0, acc} + {1'b0, addend_active};
    assign carry   = acc_sum[ACC_W];
    assign tick    = fine_mode ? carry : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc           <= '0;
            addend_active <= '0;
        end else begin
            if (fine_mode)
                acc <= acc_sum[ACC_W-1:0];
            if (take_addend)
                addend_active <= addend_stage;
        end
    end

    // half-scale addend must carry on alternate clocks
    assert_half_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_mode && $past(fine_mode) && addend_active == HALF &&
         $past(addend_active) == HALF) |-> (carry != $past(carry)));

    assert_zero_addend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_mode && addend_active == '0) |-> !tick);

endmodule

// File: rtl/ptp_tc_time.sv
module ptp_tc_time #(
    parameter int SEC_W    = 32,
    parameter int SUB_W    = 31,
    parameter int INC_W    = 8,
    parameter int DEC_ROLL = 1000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_mode,
    input  logic             tick,
    input  logic [INC_W-1:0] inc,
    input  logic             do_load,
    input  logic             do_step,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W-1:0] upd_sub,
    input  logic             upd_neg,
    output logic [SEC_W-1:0] sec_q,
    output logic [SUB_W-1:0] sub_q
);

    localparam int RW = SUB_W + 1;
    localparam logic [RW-1:0] ROLL_DEC = RW'(DEC_ROLL);
    localparam logic [RW-1:0] ROLL_BIN = RW'(1) << SUB_W;

    logic [RW-1:0]    roll;
    logic [RW-1:0]    tick_sum, tick_res;
    logic             tick_wrap;
    logic [RW-1:0]    adj_sum, adj_res;
    logic             adj_wrap;
    logic [SEC_W-1:0] adj_carry;
    logic [SEC_W-1:0] sec_nx;
    logic [SUB_W-1:0] sub_nx;

    assign roll = dec_mode ? ROLL_DEC : ROLL_BIN;

    always_comb begin
        tick_sum  = {1'b0, sub_q} + RW'(inc);
        tick_wrap = (tick_sum >= roll);
        tick_res  = tick_wrap ? (tick_sum - roll) : tick_sum;

        adj_sum   = {1'b0, sub_q} + {1'b0, upd_sub};
        adj_wrap  = (adj_sum >= roll);
        adj_res   = adj_wrap ? (adj_sum - roll) : adj_sum;
        // add: wrap carries one second in; subtract: no wrap borrows one
        if (upd_neg) adj_carry = adj_wrap ? '0 : '1;
        else         adj_carry = adj_wrap ? SEC_W'(1) : '0;

        sec_nx = sec_q;
        sub_nx = sub_q;
        if (do_load) begin
            sec_nx = upd_sec;
            sub_nx = upd_sub;
        end else if (do_step) begin
            sec_nx = sec_q + upd_sec + adj_carry;
            sub_nx = adj_res[SUB_W-1:0];
        end else if (tick) begin
            sec_nx = sec_q + SEC_W'(tick_wrap);
            sub_nx = tick_res[SUB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else begin
            sec_q <= sec_nx;
            sub_q <= sub_nx;
        end
    end

    assert_sec_with_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step) |=> ((sec_q != $past(sec_q)) == (sub_q < $past(sub_q))));

    assert_sec_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_step && !tick) |=> ($stable(sec_q) && $stable(sub_q)));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int SEC_W    = 32,
    parameter int SUB_W    = 31,
    parameter int ACC_W    = 32,
    parameter int INC_W    = 8,
    parameter int INC_LSB  = 16,
    parameter int DEC_ROLL = 1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEC_W-1:0]  time_sec,
    output logic [SUB_W-1:0]  time_sub,
    output logic [N_CMD-1:0]  cmd_pending,
    output logic [ACC_W-1:0]  addend_active
);

    logic             fine_mode, dec_mode, upd_neg, tick;
    logic             do_load, do_step, do_addend;
    logic [N_CMD-1:0] pend, clr;
    logic [INC_W-1:0] inc;
    logic [SEC_W-1:0] upd_sec;
    logic [SUB_W-1:0] upd_sub;
    logic [ACC_W-1:0] addend_stage;

    ptp_tc_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .SUB_W(SUB_W),
        .ACC_W(ACC_W), .INC_W(INC_W), .INC_LSB(INC_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr(clr), .fine_mode(fine_mode),
        .dec_mode(dec_mode), .pend(pend), .inc(inc), .upd_sec(upd_sec),
        .upd_sub(upd_sub), .upd_neg(upd_neg), .addend_stage(addend_stage)
    );

    ptp_tc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .pend(pend), .do_load(do_load),
        .do_step(do_step), .do_addend(do_addend), .clr(clr)
    );

    ptp_tc_accum #(.ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode),
        .take_addend(do_addend), .addend_stage(addend_stage),
        .addend_active(addend_active), .tick(tick)
    );

    ptp_tc_time #(
        .SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W), .DEC_ROLL(DEC_ROLL)
    ) u_time (
        .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .tick(tick), .inc(inc),
        .do_load(do_load), .do_step(do_step), .upd_sec(upd_sec),
        .upd_sub(upd_sub), .upd_neg(upd_neg), .sec_q(time_sec), .sub_q(time_sub)
    );

    assign cmd_pending = pend;

endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;

    localparam int     CLK_PERIOD = 10;
    localparam longint RDEC = 64'd1000000000;
    localparam longint RBIN = 64'd2147483648;
    localparam longint M32  = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] time_sec;
    logic [30:0] time_sub;
    logic [2:0]  cmd_pending;
    logic [31:0] addend_active;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_time_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .time_sec(time_sec), .time_sub(time_sub),
        .cmd_pending(cmd_pending), .addend_active(addend_active)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // true time arithmetic with 32-bit seconds wrap
    function automatic void tadd(input longint s, input longint sub, input longint ds,
                                 input longint dsub, input bit neg, input longint rl,
                                 output longint rs, output longint rsub);
        if (neg) begin
            rsub = sub - dsub; rs = s - ds;
            if (rsub < 0) begin rsub += rl; rs -= 1; end
        end else begin
            rsub = sub + dsub; rs = s + ds;
            if (rsub >= rl) begin rsub -= rl; rs += 1; end
        end
        rs = rs & M32;
    endfunction

    function automatic void tadv(input longint s, input longint sub, input longint inc,
                                 input int k, input longint rl,
                                 output longint rs, output longint rsub);
        rs = s; rsub = sub;
        for (int i = 0; i < k; i++) begin
            rsub += inc;
            if (rsub >= rl) begin rsub -= rl; rs += 1; end
        end
        rs = rs & M32;
    endfunction

    task automatic set_time(input bit dec, input longint s, input longint n);
        wr(3'd2, 32'(s));
        wr(3'd3, 32'(n));
        wr(3'd0, (32'(dec) << 1) | 32'h4);
        waitc(3);
    endtask

    task automatic step_time(input bit dec, input longint y, input longint x, input bit neg);
        longint rl;
        rl = dec ? RDEC : RBIN;
        if (neg) begin
            wr(3'd2, 32'((64'h1_0000_0000 - y) & M32));
            wr(3'd3, 32'h8000_0000 | 32'(rl - x));
        end else begin
            wr(3'd2, 32'(y));
            wr(3'd3, 32'(x));
        end
        wr(3'd0, (32'(dec) << 1) | 32'h8);
        waitc(3);
    endtask

    // runs k clocks after settling and checks the advance
    task automatic coarse_run(input string req, input bit dec, input longint s0,
                              input longint n0, input longint inc, input int k);
        longint rl, a_s, a_n, e_s, e_n;
        rl = dec ? RDEC : RBIN;
        wr(3'd1, 32'(inc) << 16);
        wr(3'd2, 32'(s0));
        wr(3'd3, 32'(n0));
        wr(3'd0, (32'(dec) << 1) | 32'h4);
        waitc(3);
        a_s = longint'(time_sec); a_n = longint'(time_sub);
        waitc(k);
        tadv(a_s, a_n, inc, k, rl, e_s, e_n);
        chk({req, " sec"}, longint'(time_sec), e_s);
        chk({req, " sub"}, longint'(time_sub), e_n);
        wr(3'd1, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        longint s0, n0, y, x, es, en, rl, a_s, a_n, delta, lo, cnt;
        logic [31:0] seed_v;
        bit dec, neg;
        seed_v = $urandom(32'h1588);

        waitc(3);
        rst_n = 1'b1;
        waitc(1);
        // R1 reset state
        chk("R1 sec", longint'(time_sec), 0);
        chk("R1 sub", longint'(time_sub), 0);
        chk("R1 pending", longint'(cmd_pending), 0);
        chk("R1 addend", longint'(addend_active), 0);
        waitc(2);
        chk("R1 step zero holds time", longint'(time_sub), 0);

        // R6 load timing: pending visible, cleared two clocks later
        wr(3'd2, 32'd12345);
        wr(3'd3, 32'd777);
        wr(3'd0, 32'h4);
        chk("R6 pending set", longint'(cmd_pending), 1);
        waitc(2);
        chk("R6 pending cleared", longint'(cmd_pending), 0);
        chk("R6 sec loaded", longint'(time_sec), 12345);
        chk("R6 sub loaded", longint'(time_sub), 777);

        // R7 / R8 directed: decimal add with carry, subtract with borrow
        set_time(1'b1, 100, 999_999_000);
        step_time(1'b1, 5, 2000, 1'b0);
        chk("R7 add carry sec", longint'(time_sec), 106);
        chk("R7 add carry sub", longint'(time_sub), 1000);
        step_time(1'b1, 3, 5000, 1'b1);
        chk("R8 sub borrow sec", longint'(time_sec), 102);
        chk("R8 sub borrow sub", longint'(time_sub), 999_996_000);
        set_time(1'b0, 0, 10);
        step_time(1'b0, 1, 20, 1'b1);
        chk("R8 seconds wrap sec", longint'(time_sec), M32 - 1);
        chk("R8 seconds wrap sub", longint'(time_sub), RBIN - 10);

        // R7 / R8 random in both encodings (R4 R5 rollovers)
        for (int i = 0; i < 16; i++) begin
            dec = i[0];
            rl  = dec ? RDEC : RBIN;
            s0  = longint'($urandom);
            n0  = longint'($urandom) % rl;
            y   = longint'($urandom);
            neg = $urandom % 2;
            x   = 1 + (longint'($urandom) % (rl - 1));
            set_time(dec, s0, n0);
            step_time(dec, y, x, neg);
            tadd(s0, n0, y, x, neg, rl, es, en);
            chk(neg ? "R8 random sec" : "R7 random sec", longint'(time_sec), es);
            chk(neg ? "R8 random sub" : "R7 random sub", longint'(time_sub), en);
        end

        // R10 load and step together
        wr(3'd2, 32'd40);
        wr(3'd3, 32'd600_000_000);
        wr(3'd0, 32'h2 | 32'h4 | 32'h8);
        waitc(2);
        chk("R10 step still pending", longint'(cmd_pending), 2);
        chk("R10 load first sec", longint'(time_sec), 40);
        chk("R10 load first sub", longint'(time_sub), 600_000_000);
        waitc(2);
        chk("R10 step after sec", longint'(time_sec), 81);
        chk("R10 step after sub", longint'(time_sub), 200_000_000);
        chk("R10 none pending", longint'(cmd_pending), 0);

        // R9 staged addend ignored until commanded
        wr(3'd4, 32'hDEAD_BEEF);
        waitc(3);
        chk("R9 staged ignored", longint'(addend_active), 0);
        wr(3'd0, 32'h10);
        chk("R9 pending set", longint'(cmd_pending), 4);
        waitc(2);
        chk("R9 addend taken", longint'(addend_active), 64'hDEAD_BEEF);
        chk("R9 pending cleared", longint'(cmd_pending), 0);

        // R2 coarse counting ignores addend; R4 / R5 wraps (R11 sec/sub agree)
        coarse_run("R2 coarse binary", 1'b0, 7, 1000, 13, 50);
        coarse_run("R4 decimal one-step cross", 1'b1, 9, 999_999_995, 200, 3);
        coarse_run("R4 decimal multi wrap", 1'b1, 9, 999_990_000, 255, 100);
        coarse_run("R5 binary wrap", 1'b0, M32, RBIN - 300, 250, 20);
        for (int i = 0; i < 6; i++) begin
            dec = i[0];
            rl  = dec ? RDEC : RBIN;
            coarse_run("R2 random coarse", dec, longint'($urandom),
                       rl - 1 - (longint'($urandom) % 3000),
                       1 + (longint'($urandom) % 255), 40 + i);
        end

        // R3 half-scale addend: one step per two clocks
        wr(3'd1, 32'd7 << 16);
        wr(3'd4, 32'h8000_0000);
        wr(3'd0, 32'h2 | 32'h10 | 32'h1);
        waitc(3);
        a_s = longint'(time_sec); a_n = longint'(time_sub);
        waitc(20);
        tadv(a_s, a_n, 7, 10, RDEC, es, en);
        chk("R3 half addend sub", longint'(time_sub), en);
        chk("R3 half addend sec", longint'(time_sec), es);

        // R3 zero addend: no steps
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h2 | 32'h10 | 32'h1);
        waitc(3);
        a_n = longint'(time_sub);
        waitc(30);
        chk("R3 zero addend", longint'(time_sub), a_n);

        // R3 random addends: step count within one of k*A/2^32
        for (int i = 0; i < 5; i++) begin
            y = longint'($urandom);
            wr(3'd4, 32'(y));
            wr(3'd0, 32'h2 | 32'h10 | 32'h1);
            waitc(3);
            a_s = longint'(time_sec); a_n = longint'(time_sub);
            waitc(64);
            delta = (longint'(time_sec) - a_s) * RDEC + longint'(time_sub) - a_n;
            cnt = delta / 7;
            lo  = (64 * y) >> 32;
            chk("R3 random addend rate", (cnt == lo || cnt == lo + 1) ? lo : cnt, lo);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule